// File: doc/BRIEF.md
# LED Dimmer Control Register Target on a Two-Wire Serial Bus

This block is the serial-bus front end of a three-channel LED dimming controller. It listens on an open-drain two-wire bus (clock and data), answers to one of two 7-bit device addresses chosen by a strap input, and stores what the bus master writes into a sparse map of control registers. Every register value is presented in parallel on output ports. The waveform and current logic uses these values directly.

A write is a START, the device address with the direction bit clear, a register pointer byte, and one or more data bytes, ended by a STOP. Every byte the block receives is acknowledged by pulling data low during the ninth clock. A read uses a repeated START after the pointer byte. It returns the register that the last pointer selected, once per byte, without advancing. An active-low hardware enable input puts every register back to its default and returns the bus engine to idle.

The bus lines are brought into the system clock domain through a two-flop synchroniser. All START, STOP and clock-edge detection works on the synchronised samples, so the system clock must run well above the bus clock.

Top module: `led_ctl_i2c_regs`

## Requirements
- R1: After the synchronous reset `rst`, the per-channel high-level and low-level registers read 0xE0, and all other registers read 0x00. These are the general control, time step, delay, rise, fall, high-hold and low-hold registers.
- R2: The block acknowledges device address 0x18 when `addr_sel` is 0 and device address 0x67 when `addr_sel` is 1. The address is the upper seven bits of the first byte after START. Bit 0 of that byte is the direction: 0 means write and 1 means read.
- R3: For every byte it accepts, the block pulls data low (`sda_oe`=1) for the whole high phase of the ninth clock.
- R4: The register map is as follows. 0x10 is general control and 0x20 is time step. For channel k (k=0,1,2) the upper nibble is 0xA+k, and the lower nibble selects the register: 9 high level, 8 low level, 1 delay, 5 rise, 3 high hold, 4 fall, 2 low hold. A write of pointer P then data D to a mapped P sets exactly that register to D.
- R5: A write to an unmapped pointer is acknowledged on all three bytes but changes no register.
- R6: A first byte whose address does not match is not acknowledged. Until the next START, no later byte is acknowledged and no register changes.
- R7: A read returns the register at the last written pointer. When the master acknowledges and reads again, the same register is returned; the pointer does not advance. An unmapped pointer reads 0x00.
- R8: While `hw_en_n` is low, every register is held at its R1 default. A write made after `hw_en_n` returns high works normally.
- R9: A repeated START (START with no STOP before it) restarts address decoding exactly as a first START does.
- R10: `sda_oe` changes only while the synchronised bus clock is low, and it is 0 whenever the block is idle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en_n | input | 1 | Active-low hardware enable; low clears all registers |
| addr_sel | input | 1 | Strap: 0 selects address 0x18, 1 selects 0x67 |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| gp_ctrl | output | 8 | General control register |
| step_ctrl | output | 8 | Time step register |
| ch_level_hi | output | NUM_CH*8 | High brightness level, channel k at [8k+7:8k] |
| ch_level_lo | output | NUM_CH*8 | Low brightness level per channel |
| ch_delay | output | NUM_CH*8 | Start delay per channel |
| ch_rise_step | output | NUM_CH*8 | Ramp-up step time per channel |
| ch_hold_hi | output | NUM_CH*8 | High hold time per channel |
| ch_fall_step | output | NUM_CH*8 | Ramp-down step time per channel |
| ch_hold_lo | output | NUM_CH*8 | Low hold time per channel |

## Verification
Directed writes cover each address strap setting and each kind of pointer. The pointers are the two global registers, the three channel nibbles, and unmapped values that differ from mapped ones in only one nibble. These separate correct nibble decoding from decoding that looks only at the lower or only at the upper nibble. A transaction addressed to the other strap's address shows whether the block truly ignores the bus until the next START, or only declines to acknowledge the first byte. Random writes mix mapped and random pointers with random data and strap values, and each one is compared against a full bench model of the register map. Reads through a repeated START, including a second acknowledged byte, separate a fixed pointer from an auto-incrementing one.

// File: rtl/led_i2c_pkg.sv
package led_i2c_pkg;

  localparam int REG_W   = 8;
  localparam int NUM_FLD = 7;

  localparam logic [7:0] GP_ADDR   = 8'h10;
  localparam logic [7:0] STEP_ADDR = 8'h20;
  localparam logic [3:0] CH_NIB0   = 4'hA;

  // per-channel register kinds
  typedef enum logic [2:0] {
    F_HI    = 3'd0,
    F_LO    = 3'd1,
    F_DLY   = 3'd2,
    F_RISE  = 3'd3,
    F_HHOLD = 3'd4,
    F_FALL  = 3'd5,
    F_LHOLD = 3'd6
  } fld_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } st_e;

  typedef struct packed {
    logic       hit;
    logic       gp;
    logic       step;
    logic [3:0] ch;
    fld_e       fld;
  } dec_t;

  function automatic dec_t decode_addr(input logic [7:0] a, input int num_ch);
    dec_t d;
    d     = '0;
    d.fld = F_HI;
    if (a == GP_ADDR) begin
      d.hit = 1'b1;
      d.gp  = 1'b1;
    end else if (a == STEP_ADDR) begin
      d.hit  = 1'b1;
      d.step = 1'b1;
    end else if (int'(a[7:4]) >= int'(CH_NIB0) &&
                 int'(a[7:4]) <  int'(CH_NIB0) + num_ch) begin
      d.ch  = a[7:4] - CH_NIB0;
      d.hit = 1'b1;
      case (a[3:0])
        4'h9:    d.fld = F_HI;
        4'h8:    d.fld = F_LO;
        4'h1:    d.fld = F_DLY;
        4'h5:    d.fld = F_RISE;
        4'h3:    d.fld = F_HHOLD;
        4'h4:    d.fld = F_FALL;
        4'h2:    d.fld = F_LHOLD;
        default: d.hit = 1'b0;
      endcase
    end
    return d;
  endfunction

  function automatic logic [7:0] fld_default(input fld_e f);
    return (f == F_HI || f == F_LO) ? 8'hE0 : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import led_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'h18,
  parameter logic [6:0] ADDR_HI = 7'h67
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       addr_sel,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       busy,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr
);

  localparam logic [1:0] BYTE_DEV = 2'd0;
  localparam logic [1:0] BYTE_PTR = 2'd1;
  localparam logic [1:0] BYTE_DAT = 2'd2;

  st_e        state_q;
  logic [7:0] shift_q;
  logic [3:0] bit_q;
  logic [1:0] byte_q;
  logic       rw_q;
  logic       mack_q;
  logic       sda_oe_q;
  logic       wr_en_q;
  logic [7:0] wr_data_q;
  logic [7:0] ptr_q;
  logic [6:0] dev_addr;

  assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_q     <= '0;
      byte_q    <= BYTE_DEV;
      rw_q      <= 1'b0;
      mack_q    <= 1'b1;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      ptr_q     <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_p) begin
        state_q  <= ST_RX;
        bit_q    <= '0;
        byte_q   <= BYTE_DEV;
        rw_q     <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (stop_p) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shift_q <= {shift_q[6:0], sda_s};
              bit_q   <= bit_q + 4'd1;
            end else if (scl_fall && bit_q == 4'd8) begin
              bit_q <= '0;
              case (byte_q)
                BYTE_DEV: begin
                  if (shift_q[7:1] == dev_addr) begin
                    rw_q     <= shift_q[0];
                    byte_q   <= BYTE_PTR;
                    state_q  <= ST_ACK;
                    sda_oe_q <= 1'b1;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                BYTE_PTR: begin
                  ptr_q    <= shift_q;
                  byte_q   <= BYTE_DAT;
                  state_q  <= ST_ACK;
                  sda_oe_q <= 1'b1;
                end
                default: begin
                  wr_en_q   <= 1'b1;
                  wr_data_q <= shift_q;
                  state_q   <= ST_ACK;
                  sda_oe_q  <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state_q  <= ST_TX;
                shift_q  <= rd_data;
                sda_oe_q <= ~rd_data[7];
                bit_q    <= 4'd1;
              end else begin
                state_q  <= ST_RX;
                sda_oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_TXACK;
              end else begin
                sda_oe_q <= ~shift_q[6];
                shift_q  <= {shift_q[6:0], 1'b0};
                bit_q    <= bit_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= sda_s;
            end else if (scl_fall) begin
              if (!mack_q) begin
                state_q  <= ST_TX;
                shift_q  <= rd_data;
                sda_oe_q <= ~rd_data[7];
                bit_q    <= 4'd1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = sda_oe_q;
  assign busy    = (state_q != ST_IDLE);
  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;
  assign ptr     = ptr_q;

endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank
  import led_i2c_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int VEC_W = NUM_CH * NUM_FLD * REG_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [7:0]       gp_q,
  output logic [7:0]       step_q,
  output logic [VEC_W-1:0] fld_vec
);

  dec_t wdec, rdec;

  always_comb wdec = decode_addr(wr_addr, NUM_CH);
  always_comb rdec = decode_addr(rd_addr, NUM_CH);

  always_ff @(posedge clk) begin
    if (clr) begin
      gp_q   <= '0;
      step_q <= '0;
    end else if (wr_en && wdec.hit) begin
      if (wdec.gp)   gp_q   <= wr_data;
      if (wdec.step) step_q <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      logic [7:0] q;
      logic       we;
      assign we = wr_en && wdec.hit && !wdec.gp && !wdec.step &&
                  int'(wdec.ch) == c && int'(wdec.fld) == f;
      always_ff @(posedge clk) begin
        if (clr)     q <= fld_default(fld_e'(f));
        else if (we) q <= wr_data;
      end
      assign fld_vec[(c*NUM_FLD+f)*REG_W +: REG_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rdec.hit) begin
      if (rdec.gp)        rd_data = gp_q;
      else if (rdec.step) rd_data = step_q;
      else begin
        for (int c = 0; c < NUM_CH; c++) begin
          for (int f = 0; f < NUM_FLD; f++) begin
            if (int'(rdec.ch) == c && int'(rdec.fld) == f)
              rd_data = fld_vec[(c*NUM_FLD+f)*REG_W +: REG_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/led_ctl_i2c_regs.sv
module led_ctl_i2c_regs
  import led_i2c_pkg::*;
#(
  parameter int         NUM_CH      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h18,
  parameter logic [6:0] ADDR_HI     = 7'h67,
  localparam int        CH_VEC_W    = NUM_CH * REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hw_en_n,
  input  logic                addr_sel,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  output logic [7:0]          gp_ctrl,
  output logic [7:0]          step_ctrl,
  output logic [CH_VEC_W-1:0] ch_level_hi,
  output logic [CH_VEC_W-1:0] ch_level_lo,
  output logic [CH_VEC_W-1:0] ch_delay,
  output logic [CH_VEC_W-1:0] ch_rise_step,
  output logic [CH_VEC_W-1:0] ch_hold_hi,
  output logic [CH_VEC_W-1:0] ch_fall_step,
  output logic [CH_VEC_W-1:0] ch_hold_lo
);

  localparam int VEC_W = NUM_CH * NUM_FLD * REG_W;

  logic             clr;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic             busy, wr_en;
  logic [7:0]       wr_data, ptr, rd_data;
  logic [VEC_W-1:0] fld_vec;

  assign clr = rst | ~hw_en_n;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2c_target_fsm #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk      (clk),
    .clr      (clr),
    .addr_sel (addr_sel),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr      (ptr)
  );

  led_reg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .gp_q    (gp_ctrl),
    .step_q  (step_ctrl),
    .fld_vec (fld_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    localparam int B = c * NUM_FLD;
    assign ch_level_hi [c*REG_W +: REG_W] = fld_vec[(B+int'(F_HI))   *REG_W +: REG_W];
    assign ch_level_lo [c*REG_W +: REG_W] = fld_vec[(B+int'(F_LO))   *REG_W +: REG_W];
    assign ch_delay    [c*REG_W +: REG_W] = fld_vec[(B+int'(F_DLY))  *REG_W +: REG_W];
    assign ch_rise_step[c*REG_W +: REG_W] = fld_vec[(B+int'(F_RISE)) *REG_W +: REG_W];
    assign ch_hold_hi  [c*REG_W +: REG_W] = fld_vec[(B+int'(F_HHOLD))*REG_W +: REG_W];
    assign ch_fall_step[c*REG_W +: REG_W] = fld_vec[(B+int'(F_FALL)) *REG_W +: REG_W];
    assign ch_hold_lo  [c*REG_W +: REG_W] = fld_vec[(B+int'(F_LHOLD))*REG_W +: REG_W];
  end

endmodule

// File: rtl/led_i2c_chk.sv
module led_i2c_chk #(
  parameter int NUM_CH = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hw_en_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  busy,
  input logic                  wr_en,
  input logic [7:0]            gp_ctrl,
  input logic [7:0]            step_ctrl,
  input logic [NUM_CH*8-1:0]   ch_level_hi,
  input logic [NUM_CH*8-1:0]   ch_level_lo,
  input logic [NUM_CH*8-1:0]   ch_delay
);

  // R8
  hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!hw_en_n) |-> (gp_ctrl == 8'h00 && step_ctrl == 8'h00 &&
                         ch_level_hi == {NUM_CH{8'hE0}} &&
                         ch_level_lo == {NUM_CH{8'hE0}} &&
                         ch_delay == '0));

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst || !hw_en_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_oe);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hw_en_n) && hw_en_n && !$past(wr_en)) |->
      ($stable(gp_ctrl) && $stable(step_ctrl) && $stable(ch_level_hi) &&
       $stable(ch_level_lo) && $stable(ch_delay)));

  // R4
  wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

endmodule

bind led_ctl_i2c_regs led_i2c_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_en_n     (hw_en_n),
  .scl_s       (scl_s),
  .sda_oe      (sda_oe),
  .busy        (busy),
  .wr_en       (wr_en),
  .gp_ctrl     (gp_ctrl),
  .step_ctrl   (step_ctrl),
  .ch_level_hi (ch_level_hi),
  .ch_level_lo (ch_level_lo),
  .ch_delay    (ch_delay)
);

// File: tb/test_led_ctl_i2c_regs.sv
module test_led_ctl_i2c_regs;

  localparam int NUM_CH = 3;
  localparam int Q      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_en_n = 1'b1;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [7:0] gp_ctrl, step_ctrl;
  logic [NUM_CH*8-1:0] ch_level_hi, ch_level_lo, ch_delay, ch_rise_step;
  logic [NUM_CH*8-1:0] ch_hold_hi, ch_fall_step, ch_hold_lo;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  led_ctl_i2c_regs #(.NUM_CH(NUM_CH)) i_led_ctl_i2c_regs (
    .clk(clk), .rst(rst), .hw_en_n(hw_en_n), .addr_sel(addr_sel),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .gp_ctrl(gp_ctrl), .step_ctrl(step_ctrl),
    .ch_level_hi(ch_level_hi), .ch_level_lo(ch_level_lo), .ch_delay(ch_delay),
    .ch_rise_step(ch_rise_step), .ch_hold_hi(ch_hold_hi),
    .ch_fall_step(ch_fall_step), .ch_hold_lo(ch_hold_lo)
  );

  // low nibbles in the order of the field outputs (R4)
  function automatic logic [3:0] fld_nib(input int f);
    case (f)
      0: return 4'h9; 1: return 4'h8; 2: return 4'h1; 3: return 4'h5;
      4: return 4'h3; 5: return 4'h4; default: return 4'h2;
    endcase
  endfunction

  function automatic bit is_mapped(input logic [7:0] a);
    if (a == 8'h10 || a == 8'h20) return 1'b1;
    if (a[7:4] < 4'hA || a[7:4] > 4'hC) return 1'b0;
    for (int f = 0; f < 7; f++) if (a[3:0] == fld_nib(f)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] def_val(input logic [7:0] a);
    if (is_mapped(a) && (a[3:0] == 4'h9 || a[3:0] == 4'h8) && a[7:4] >= 4'hA)
      return 8'hE0;
    return 8'h00;
  endfunction

  function automatic logic [7:0] get_out(input int c, input int f);
    case (f)
      0: return ch_level_hi[c*8 +: 8];
      1: return ch_level_lo[c*8 +: 8];
      2: return ch_delay[c*8 +: 8];
      3: return ch_rise_step[c*8 +: 8];
      4: return ch_hold_hi[c*8 +: 8];
      5: return ch_fall_step[c*8 +: 8];
      default: return ch_hold_lo[c*8 +: 8];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 256; a++) mdl[a] = def_val(8'(a));
  endtask

  task automatic check_regs(input string tag);
    chk(gp_ctrl == mdl[8'h10], {tag, " gp"}, gp_ctrl, mdl[8'h10]);
    chk(step_ctrl == mdl[8'h20], {tag, " step"}, step_ctrl, mdl[8'h20]);
    for (int c = 0; c < NUM_CH; c++)
      for (int f = 0; f < 7; f++) begin
        logic [7:0] a;
        a = {4'(4'hA + c), fld_nib(f)};
        chk(get_out(c, f) == mdl[a], $sformatf("%s reg %0h", tag, a),
            get_out(c, f), mdl[a]);
      end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    ack = (sda_bus == 1'b0) && (sda_oe == 1'b1);
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b[i] = sda_bus; wq(); m_scl = 1'b0; wq();
    end
    m_sda = master_ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  function automatic logic [6:0] dev_of(input logic sel);
    return sel ? 7'h67 : 7'h18;
  endfunction

  task automatic reg_write(input logic [6:0] dev, input logic [7:0] a,
                           input logic [7:0] d, output bit [2:0] acks);
    bit k;
    bus_start();
    send_byte({dev, 1'b0}, k); acks[0] = k;
    send_byte(a, k);           acks[1] = k;
    send_byte(d, k);           acks[2] = k;
    bus_stop();
  endtask

  // pointer write, repeated START, then one or two read bytes
  task automatic reg_read(input logic [6:0] dev, input logic [7:0] a, input bit twice,
                          output logic [7:0] d0, output logic [7:0] d1,
                          output bit [2:0] acks);
    bit k;
    bus_start();
    send_byte({dev, 1'b0}, k); acks[0] = k;
    send_byte(a, k);           acks[1] = k;
    bus_start();
    send_byte({dev, 1'b1}, k); acks[2] = k;
    recv_byte(twice, d0);
    d1 = d0;
    if (twice) recv_byte(1'b0, d1);
    bus_stop();
  endtask

  task automatic write_and_check(input logic [7:0] a, input logic [7:0] d,
                                 input string tag);
    bit [2:0] acks;
    reg_write(dev_of(addr_sel), a, d, acks);
    chk(acks == 3'b111, {tag, " R3 acks"}, acks, 3'b111);
    if (is_mapped(a)) mdl[a] = d;
    wq();
    check_regs(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit [2:0] acks;
    logic [7:0] d0, d1;
    void'($urandom(32'd2755));
    model_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 defaults after reset
    check_regs("R1");
    chk(sda_oe == 1'b0, "R1 sda_oe idle", sda_oe, 0);

    // R2 low strap address, R4 mapped writes
    addr_sel = 1'b0;
    write_and_check(8'h10, 8'h3F, "R2 R4 gp");
    write_and_check(8'h20, 8'h05, "R4 step");
    write_and_check(8'hA9, 8'h1F, "R4 ch0 hi");
    write_and_check(8'hC2, 8'h77, "R4 ch2 lhold");
    // R2 high strap address
    addr_sel = 1'b1;
    write_and_check(8'hB5, 8'h44, "R2 R4 ch1 rise");

    // R6 other strap's address is ignored until next START
    reg_write(7'h18, 8'hB5, 8'h99, acks);
    chk(acks == 3'b000, "R6 no ack", acks, 0);
    wq();
    check_regs("R6");
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);

    // R5 unmapped pointers ack but change nothing
    write_and_check(8'h33, 8'hAA, "R5 unmapped 33");
    write_and_check(8'hA0, 8'hAA, "R5 unmapped A0");
    write_and_check(8'hD9, 8'hAA, "R5 unmapped D9");
    write_and_check(8'h19, 8'hAA, "R5 unmapped 19");

    // R7 R9 read through repeated start, no auto-increment
    reg_read(7'h67, 8'hB5, 1'b1, d0, d1, acks);
    chk(acks == 3'b111, "R9 repeated start acks", acks, 3'b111);
    chk(d0 == 8'h44, "R7 read first", d0, 8'h44);
    chk(d1 == 8'h44, "R7 read again same reg", d1, 8'h44);
    reg_read(7'h67, 8'hA8, 1'b0, d0, d1, acks);
    chk(d0 == 8'hE0, "R7 read default lo", d0, 8'hE0);
    reg_read(7'h67, 8'h55, 1'b0, d0, d1, acks);
    chk(d0 == 8'h00, "R7 unmapped reads zero", d0, 8'h00);

    // R8 hardware enable clears all
    @(negedge clk); hw_en_n = 1'b0;
    repeat (4) @(negedge clk);
    model_reset();
    check_regs("R8 held low");
    hw_en_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R8 after release");
    write_and_check(8'hC9, 8'h12, "R8 write after release");

    // random mix
    for (int it = 0; it < 36; it++) begin
      logic [7:0] a;
      addr_sel = 1'($urandom % 2);
      case ($urandom % 4)
        0: a = 8'($urandom);
        1: a = ($urandom % 2) ? 8'h10 : 8'h20;
        default: a = {4'(4'hA + ($urandom % 3)), fld_nib(int'($urandom % 7))};
      endcase
      write_and_check(a, 8'($urandom), $sformatf("R4 R5 rnd%0d", it));
      if (it % 4 == 3) begin
        logic [7:0] ra;
        ra = {4'(4'hA + ($urandom % 3)), fld_nib(int'($urandom % 7))};
        reg_read(dev_of(addr_sel), ra, 1'b1, d0, d1, acks);
        chk(d0 == mdl[ra] && d1 == mdl[ra], "R7 R9 rnd read", {d0, d1}, {mdl[ra], mdl[ra]});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule